// File: doc/BRIEF.md
# Serial Bit-Rate and Clock-Edge Generator

This block supplies all bit timing for a serial port that can run either framed asynchronous traffic or clocked synchronous traffic. A single 16-bit divisor register sets the rate. In asynchronous mode a down-counter built on the full divisor emits an oversampling tick. A second counter groups those ticks into bit periods of 16, 8 or 3 samples. In synchronous mode the block can run in one of two ways. It can generate a continuous serial clock from the low byte of the divisor and drive it on a pad. It can also take a serial clock from outside, synchronise it and detect its edges in the system clock domain.

In synchronous mode a polarity input picks which clock edge is the transmit-change edge. The opposite edge is the receive-sample edge. The block turns each edge into a one-cycle strobe: `shift_stb` for transmit change and `sample_stb` for receive sample. A shift register elsewhere uses these strobes. The divisor can only be loaded while the block is disabled. Enabling the block restarts every counter from a known phase, so the first tick lands exactly one period after enable.

Top module: `sclk_gen`

## Requirements
- R1: In asynchronous mode (`sync_mode`=0), `os_tick` pulses for one cycle every P system cycles, where P is the full 16-bit divisor value and a divisor of 0 counts as 1.
- R2: In synchronous mode with the internal source (`int_src`=1), `xck_out` toggles every P cycles, where P is the divisor's low 8 bits and 0 counts as 1. The upper 8 bits have no effect.
- R3: `bit_tick` pulses together with every Nth `os_tick`, counted from enable. N depends on `ovs_sel`: 0 gives 16, 1 gives 8, 2 gives 3, and 3 is treated as 16.
- R4: With `cpol`=0, `shift_stb` pulses on rising clock edges and `sample_stb` on falling ones. For the internal clock, `xck_out` is 1 in the cycle `shift_stb` is high and 0 in the cycle `sample_stb` is high.
- R5: With `cpol`=1 the two edges swap. `shift_stb` pulses on falling edges, with `xck_out` at 0, and `sample_stb` pulses on rising edges, with `xck_out` at 1.
- R6: `xck_oe` is 1 only while the block is enabled in synchronous mode with the internal source. With the external source, each edge of `xck_in` produces exactly one strobe of the kind R4/R5 assign to it, after a two-flop synchroniser.
- R7: A pulse on `div_wr` loads `div_wdata` only while `enable`=0. While the block is enabled a write is ignored, and the old divisor stays in force.
- R8: While disabled the block emits no strobes and `xck_out` rests at `cpol`. After `enable` rises, the first tick appears exactly P cycles later.
- R9: `shift_stb` and `sample_stb` never fire in asynchronous mode. `os_tick` and `bit_tick` never fire in synchronous mode. `shift_stb` and `sample_stb` are never high together.
- R10: While `rst` is high all strobes and `xck_oe` are 0, and the divisor register is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; low restarts all counters |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous |
| int_src | input | 1 | Synchronous clock source: 1 internal, 0 external |
| cpol | input | 1 | Edge polarity select |
| ovs_sel | input | 2 | Oversampling ratio select |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 16 | Divisor write value |
| xck_in | input | 1 | External serial clock |
| xck_out | output | 1 | Generated serial clock level |
| xck_oe | output | 1 | Pad output enable for the serial clock |
| os_tick | output | 1 | Asynchronous oversample tick |
| bit_tick | output | 1 | Asynchronous bit-period tick |
| shift_stb | output | 1 | Transmit data change strobe |
| sample_stb | output | 1 | Receive data sample strobe |

## Verification
The oversample tick and the bit tick coincide on the last sample of each bit. The hardest case is a divisor of 0 with a ratio of 3, where a tick arrives every cycle and a bit tick every third cycle. The scoreboard expects the combined event on every third item with a gap of exactly one cycle, so a bit tick that is early, late or separate is reported. A divisor write can also arrive in the same cycle as running ticks. The bench writes while enabled, restarts, and checks that the spacing still follows the old divisor.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int DIV_W  = 16;
  localparam int SYNC_W = 8;
  localparam int OVS_W  = 5;

  typedef enum logic [1:0] {
    OVS_16 = 2'd0,
    OVS_8  = 2'd1,
    OVS_3  = 2'd2,
    OVS_RSV = 2'd3
  } ovs_e;

  function automatic logic [OVS_W-1:0] ovs_ratio(input logic [1:0] sel);
    case (sel)
      OVS_8:   return OVS_W'(8);
      OVS_3:   return OVS_W'(3);
      default: return OVS_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int DIV_W  = 16,
  parameter int SYNC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             enable,
  input  logic             wide,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] sel_div;
  logic [DIV_W-1:0] reload;

  always_comb begin
    sel_div = wide ? div_q : {{(DIV_W-SYNC_W){1'b0}}, div_q[SYNC_W-1:0]};
    reload  = (sel_div == '0) ? '0 : sel_div - DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (div_wr && !enable) begin
      div_q <= div_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= reload;
    end else if (cnt_q == '0) begin
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/sclk_ovs.sv
module sclk_ovs #(
  parameter int OVS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  logic [OVS_W-1:0] ratio,
  output logic             wrap
);
  logic [OVS_W-1:0] idx_q;

  assign wrap = run && step && (idx_q == ratio - OVS_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      idx_q <= '0;
    end else if (wrap) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= idx_q + OVS_W'(1);
    end
  end
endmodule

// File: rtl/sclk_edge.sv
module sclk_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-1:0], din};
    end
  end

  assign rise = chain_q[STAGES-1] && !chain_q[STAGES];
  assign fall = !chain_q[STAGES-1] && chain_q[STAGES];
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             sync_mode,
  input  logic             int_src,
  input  logic             cpol,
  input  logic [1:0]       ovs_sel,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             xck_in,
  output logic             xck_out,
  output logic             xck_oe,
  output logic             os_tick,
  output logic             bit_tick,
  output logic             shift_stb,
  output logic             sample_stb
);
  logic run_async, run_int, run_ext, run_div;
  logic tick, wrap, ext_rise, ext_fall;
  logic xck_q, os_q, bit_q, shift_q, sample_q, oe_q;

  assign run_async = enable && !sync_mode;
  assign run_int   = enable && sync_mode && int_src;
  assign run_ext   = enable && sync_mode && !int_src;
  assign run_div   = run_async || run_int;

  sclk_divider #(.DIV_W(DIV_W), .SYNC_W(SYNC_W)) u_div (
    .clk(clk), .rst(rst), .run(run_div), .enable(enable), .wide(!sync_mode),
    .div_wr(div_wr), .div_wdata(div_wdata), .tick(tick)
  );

  sclk_ovs #(.OVS_W(OVS_W)) u_ovs (
    .clk(clk), .rst(rst), .run(run_async), .step(tick),
    .ratio(ovs_ratio(ovs_sel)), .wrap(wrap)
  );

  sclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(xck_in), .rise(ext_rise), .fall(ext_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xck_q    <= cpol;
      os_q     <= 1'b0;
      bit_q    <= 1'b0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      os_q  <= run_async && tick;
      bit_q <= run_async && wrap;
      oe_q  <= run_int;
      if (!run_int) begin
        xck_q <= cpol;
      end else if (tick) begin
        xck_q <= !xck_q;
      end
      if (run_int) begin
        shift_q  <= tick && (xck_q == cpol);
        sample_q <= tick && (xck_q != cpol);
      end else if (run_ext) begin
        shift_q  <= cpol ? ext_fall : ext_rise;
        sample_q <= cpol ? ext_rise : ext_fall;
      end else begin
        shift_q  <= 1'b0;
        sample_q <= 1'b0;
      end
    end
  end

  assign xck_out    = xck_q;
  assign xck_oe     = oe_q;
  assign os_tick    = os_q;
  assign bit_tick   = bit_q;
  assign shift_stb  = shift_q;
  assign sample_stb = sample_q;
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
  input logic clk,
  input logic rst,
  input logic sync_mode,
  input logic int_src,
  input logic cpol,
  input logic xck_out,
  input logic xck_oe,
  input logic os_tick,
  input logic bit_tick,
  input logic shift_stb,
  input logic sample_stb
);
  // R4 / R5: internal clock level agrees with the strobe kind
  assert_shift_level_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_stb && xck_oe) |-> (xck_out != cpol));
  assert_sample_level_R5: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && xck_oe) |-> (xck_out == cpol));
  // R9: the two synchronous strobes are exclusive
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({shift_stb, sample_stb}) <= 1);
  // R9: no asynchronous ticks in synchronous mode
  assert_no_async_in_sync_R9: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && $past(sync_mode)) |-> (!os_tick && !bit_tick));
  // R9: no synchronous strobes in asynchronous mode
  assert_no_sync_in_async_R9: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && $past(!sync_mode)) |-> (!shift_stb && !sample_stb));
  // R3: a bit tick always rides on an oversample tick
  assert_bit_on_os_R3: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);
  // R6: external source never drives the pad
  assert_ext_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    !int_src |=> !xck_oe);
  // R2: a driven clock only moves together with a strobe
  assert_xck_moves_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (xck_oe && $past(xck_oe) && (xck_out != $past(xck_out))) |-> (shift_stb || sample_stb));
endmodule

bind sclk_gen sclk_gen_chk chk_i (
  .clk(clk), .rst(rst), .sync_mode(sync_mode), .int_src(int_src), .cpol(cpol),
  .xck_out(xck_out), .xck_oe(xck_oe), .os_tick(os_tick), .bit_tick(bit_tick),
  .shift_stb(shift_stb), .sample_stb(sample_stb)
);

// File: tb/sclk_gen_tb_top.sv
module sclk_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, sync_mode = 1'b0, int_src = 1'b1, cpol = 1'b0;
  logic [1:0] ovs_sel = 2'd0;
  logic div_wr = 1'b0;
  logic [15:0] div_wdata = '0;
  logic xck_in = 1'b0;
  logic xck_out, xck_oe, os_tick, bit_tick, shift_stb, sample_stb;

  always #4 clk = ~clk;

  sclk_gen dut_i (
    .clk(clk), .rst(rst), .enable(enable), .sync_mode(sync_mode), .int_src(int_src),
    .cpol(cpol), .ovs_sel(ovs_sel), .div_wr(div_wr), .div_wdata(div_wdata),
    .xck_in(xck_in), .xck_out(xck_out), .xck_oe(xck_oe), .os_tick(os_tick),
    .bit_tick(bit_tick), .shift_stb(shift_stb), .sample_stb(sample_stb)
  );

  localparam logic [3:0] K_SA = 4'b0001, K_SH = 4'b0010, K_OS = 4'b0100, K_BIT = 4'b1100;

  typedef struct {
    logic [3:0] kind;
    int         gap;
    logic       lvl_care;
    logic       lvl;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int cyc = 0, last_cyc = 0, n_tests = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as events appear
  always @(negedge clk) begin
    logic [3:0] ev;
    ev = {bit_tick, os_tick, shift_stb, sample_stb};
    if (ev != 4'b0) begin
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check(ev == it.kind, {it.tag, " kind"}, ev, it.kind);
        if (it.gap != 0) check(cyc - last_cyc == it.gap, {it.tag, " gap"}, cyc - last_cyc, it.gap);
        if (it.lvl_care) check(xck_out == it.lvl, {it.tag, " xck level"}, xck_out, it.lvl);
      end
      last_cyc = cyc;
    end
  end

  task automatic push(input logic [3:0] k, input int g, input logic care, input logic l, input string t);
    item_t it;
    it.kind = k; it.gap = g; it.lvl_care = care; it.lvl = l; it.tag = t;
    exp_q.push_back(it);
  endtask

  task automatic write_div(input logic [15:0] v);
    @(negedge clk); div_wr = 1'b1; div_wdata = v;
    @(negedge clk); div_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_run();
    @(negedge clk); last_cyc = cyc; enable = 1'b1;
  endtask

  task automatic wait_empty(input int limit, input string tag);
    int k = 0;
    while (exp_q.size() != 0 && k < limit) begin @(negedge clk); k++; end
    check(exp_q.size() == 0, {tag, " all expected events seen"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic stop_run();
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_check(input string tag);
    int seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if ({bit_tick, os_tick, shift_stb, sample_stb} != 4'b0) seen++;
      if (xck_out != cpol) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  task automatic ext_edge(input logic v, input logic [3:0] k, input string t);
    push(k, 0, 1'b0, 1'b0, t);
    @(negedge clk); xck_in = v;
    wait_empty(10, t);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({os_tick, bit_tick, shift_stb, sample_stb, xck_oe} == 5'b0, "R10 reset outputs",
          {os_tick, bit_tick, shift_stb, sample_stb, xck_oe}, 0);
    @(negedge clk); rst = 1'b0;
    // R10: divisor cleared -> P=1 in async mode
    sync_mode = 1'b0; ovs_sel = 2'd2;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 6; i++) push((i % 3 == 2) ? K_BIT : K_OS, 1, 1'b0, 1'b0, "R10 cleared divisor");
    start_run(); wait_empty(100, "R10"); stop_run();

    // R1 + R3: divisor 3, ratio 8
    ovs_sel = 2'd1; write_div(16'd3);
    for (int i = 0; i < 16; i++) push((i % 8 == 7) ? K_BIT : K_OS, 3, 1'b0, 1'b0, "R1/R3 div3 ovs8");
    start_run(); wait_empty(200, "R1"); stop_run();
    idle_check("R8 no strobes while disabled");

    // R3: divisor 0 treated as 1, ratio 3, os and bit together
    ovs_sel = 2'd2; write_div(16'd0);
    for (int i = 0; i < 9; i++) push((i % 3 == 2) ? K_BIT : K_OS, 1, 1'b0, 1'b0, "R3 div0 ovs3");
    start_run(); wait_empty(100, "R3 ovs3"); stop_run();

    // R3: ratio 16 and reserved code 3
    ovs_sel = 2'd0; write_div(16'd1);
    for (int i = 0; i < 32; i++) push((i % 16 == 15) ? K_BIT : K_OS, 1, 1'b0, 1'b0, "R3 ovs16");
    start_run(); wait_empty(100, "R3 ovs16"); stop_run();
    ovs_sel = 2'd3;
    for (int i = 0; i < 16; i++) push((i % 16 == 15) ? K_BIT : K_OS, 1, 1'b0, 1'b0, "R3 reserved ratio");
    start_run(); wait_empty(100, "R3 reserved"); stop_run();

    // R1: full 16-bit divisor in async mode
    write_div(16'h0102);
    for (int i = 0; i < 3; i++) push(K_OS, 258, 1'b0, 1'b0, "R1 wide divisor");
    start_run(); wait_empty(1200, "R1 wide"); stop_run();

    // R2 + R4: sync internal, same divisor, low byte 2
    sync_mode = 1'b1; int_src = 1'b1; cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(xck_out == 1'b0, "R8 idle level cpol0", xck_out, 0);
    for (int i = 0; i < 6; i++)
      if (i % 2 == 0) push(K_SH, 2, 1'b1, 1'b1, "R2/R4 shift on rise");
      else            push(K_SA, 2, 1'b1, 1'b0, "R2/R4 sample on fall");
    start_run();
    @(negedge clk);
    check(xck_oe == 1'b1, "R6 oe internal", xck_oe, 1);
    wait_empty(100, "R2"); stop_run();
    check(xck_oe == 1'b0, "R6 oe off when disabled", xck_oe, 0);

    // R5: cpol 1, divisor 1
    cpol = 1'b1; write_div(16'd1);
    check(xck_out == 1'b1, "R8 idle level cpol1", xck_out, 1);
    for (int i = 0; i < 6; i++)
      if (i % 2 == 0) push(K_SH, 1, 1'b1, 1'b0, "R5 shift on fall");
      else            push(K_SA, 1, 1'b1, 1'b1, "R5 sample on rise");
    start_run(); wait_empty(100, "R5"); stop_run();
    idle_check("R8 sync idle");

    // R7: write while enabled is ignored
    cpol = 1'b0; write_div(16'd2);
    start_run(); repeat (10) @(negedge clk);
    div_wr = 1'b1; div_wdata = 16'd5;
    @(negedge clk); div_wr = 1'b0;
    stop_run();
    for (int i = 0; i < 4; i++) push((i % 2 == 0) ? K_SH : K_SA, 2, 1'b0, 1'b0, "R7 write ignored");
    start_run(); wait_empty(100, "R7 ignored"); stop_run();
    write_div(16'd5);
    for (int i = 0; i < 4; i++) push((i % 2 == 0) ? K_SH : K_SA, 5, 1'b0, 1'b0, "R7 write taken");
    start_run(); wait_empty(100, "R7 taken"); stop_run();

    // R6: external clock, both polarities
    int_src = 1'b0; cpol = 1'b0;
    start_run(); repeat (3) @(negedge clk);
    check(xck_oe == 1'b0, "R6 oe external", xck_oe, 0);
    for (int i = 0; i < 3; i++) begin
      ext_edge(1'b1, K_SH, "R6/R4 ext rise shift");
      ext_edge(1'b0, K_SA, "R6/R4 ext fall sample");
    end
    stop_run();
    cpol = 1'b1; start_run(); repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      ext_edge(1'b1, K_SA, "R6/R5 ext rise sample");
      ext_edge(1'b0, K_SH, "R6/R5 ext fall shift");
    end
    stop_run();

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule